// File: doc/BRIEF.md
# Segmented Address Generation Unit

This unit turns a segment:offset pointer into a 20-bit physical address. It holds four 16-bit segment registers, loaded through a single write port. An address request picks one of the four registers and supplies a 16-bit offset. The physical address is the segment shifted left by four bit positions plus the offset. Because segment bases sit on 16-byte paragraph boundaries, many segment:offset pairs resolve to the same physical byte.

The same request path also performs pointer arithmetic. The pointer's segment comes from the selected register and its offset comes from the request. A signed 32-bit delta is applied in one of two modes. In far mode only the offset moves, and it wraps within its 16 bits. In huge mode the pointer is first flattened to its 20-bit linear address, the delta is added, and the result is split back into a normalized segment:offset pair whose offset is below 16. Every accepted request returns one registered result, one cycle later, marked by a single-cycle valid pulse.

Top module: `seg_addr_unit`

## Requirements
- R1: After reset all four segment registers read as zero, so an address request with offset X returns physical address X.
- R2: An address request (req_arith=0) returns out_phys = (segment * 16 + offset) mod 2^20, with out_seg equal to the selected segment and out_off equal to the request offset.
- R3: Different segment:offset pairs naming the same byte (for example 0x1000:0x0000, 0x0FFF:0x0010 and 0x0001:0xFFF0) all return the same physical address.
- R4: A segment write (wr_en, wr_sel, wr_data) takes effect at the next clock edge. A request that reads the same register in the write cycle sees the old value.
- R5: Far arithmetic (req_arith=1, req_huge=0) returns out_off = (offset + delta[15:0]) mod 65536 and leaves out_seg equal to the selected segment. Delta bits above 15 have no effect.
- R6: Huge arithmetic (req_arith=1, req_huge=1) computes L = (segment*16 + offset + delta) mod 2^20, with the delta sign-extended. It returns out_seg = L[19:4] and out_off = {12'b0, L[3:0]}.
- R7: A physical or linear sum above 0xFFFFF wraps modulo 2^20, and no carry out of bit 19 appears.
- R8: out_valid is high for exactly the one cycle after each cycle in which req_valid is high, and is low otherwise, including after reset.
- R9: For arithmetic requests out_phys is the physical address of the resulting pointer, out_seg*16 + out_off mod 2^20.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Segment register write enable |
| wr_sel | input | 2 | Segment register to write |
| wr_data | input | 16 | Value to write |
| req_valid | input | 1 | Request strobe |
| req_arith | input | 1 | 0 = address request, 1 = pointer arithmetic |
| req_huge | input | 1 | Arithmetic mode: 0 = far, 1 = huge |
| req_sel | input | 2 | Segment register used by the request |
| req_off | input | 16 | Request offset |
| req_delta | input | 32 | Signed delta for arithmetic |
| out_valid | output | 1 | Result valid pulse |
| out_phys | output | 20 | Physical address of the result |
| out_seg | output | 16 | Result segment |
| out_off | output | 16 | Result offset |

## Verification
The hardest cases to reach are carries that cross a field boundary: a huge-mode carry out of the offset into the segment, and a sum that goes past the top of the 1 MB space. The stimulus loads registers near 0xFFFF and 0x2000 and then issues offsets and deltas placed so that these carries happen. It also issues a write and a read of the same register in the same cycle, which shows that the read takes the old value.

// File: rtl/seg_addr_pkg.sv
package seg_addr_pkg;
  localparam int SEG_W   = 16;
  localparam int OFF_W   = 16;
  localparam int SHIFT   = 4;
  localparam int NUM_SEG = 4;
  localparam int DELTA_W = 32;
  localparam int PHYS_W  = SEG_W + SHIFT;
  localparam int SEL_W   = $clog2(NUM_SEG);

  typedef enum logic {MODE_FAR = 1'b0, MODE_HUGE = 1'b1} ptr_mode_e;

  typedef struct packed {
    logic [SEG_W-1:0] seg;
    logic [OFF_W-1:0] off;
  } far_ptr_t;
endpackage

// File: rtl/seg_regfile.sv
module seg_regfile
  import seg_addr_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [SEL_W-1:0]         wr_sel,
  input  logic [SEG_W-1:0]         wr_data,
  input  logic [SEL_W-1:0]         rd_sel,
  output logic [SEG_W-1:0]         rd_data,
  output logic [NUM_SEG*SEG_W-1:0] seg_flat
);
  logic [SEG_W-1:0] seg_q [NUM_SEG];

  for (genvar i = 0; i < NUM_SEG; i++) begin : g_seg
    logic load;
    assign load = wr_en && (wr_sel == SEL_W'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        seg_q[i] <= '0;
      end else if (load) begin
        seg_q[i] <= wr_data;
      end
    end
    assign seg_flat[i*SEG_W +: SEG_W] = seg_q[i];
  end

  assign rd_data = seg_q[rd_sel];
endmodule

// File: rtl/seg_phys_calc.sv
module seg_phys_calc
  import seg_addr_pkg::*;
(
  input  logic [SEG_W-1:0]  seg,
  input  logic [OFF_W-1:0]  off,
  output logic [PHYS_W-1:0] phys
);
  logic [PHYS_W-1:0] base;
  logic [PHYS_W-1:0] off_ext;

  always_comb begin
    base    = {seg, {SHIFT{1'b0}}};
    off_ext = PHYS_W'(off);
    phys    = base + off_ext;
  end
endmodule

// File: rtl/seg_ptr_math.sv
module seg_ptr_math
  import seg_addr_pkg::*;
(
  input  far_ptr_t             ptr_in,
  input  ptr_mode_e            mode,
  input  logic [DELTA_W-1:0]   delta,
  input  logic [PHYS_W-1:0]    lin_in,
  output far_ptr_t             ptr_out
);
  logic [OFF_W-1:0]  far_off;
  logic [PHYS_W-1:0] lin_sum;

  always_comb begin
    far_off = ptr_in.off + delta[OFF_W-1:0];
    lin_sum = lin_in + delta[PHYS_W-1:0];
    if (mode == MODE_HUGE) begin
      ptr_out.seg = lin_sum[PHYS_W-1:SHIFT];
      ptr_out.off = OFF_W'(lin_sum[SHIFT-1:0]);
    end else begin
      ptr_out.seg = ptr_in.seg;
      ptr_out.off = far_off;
    end
  end
endmodule

// File: rtl/seg_addr_unit.sv
module seg_addr_unit
  import seg_addr_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [1:0]         wr_sel,
  input  logic [15:0]        wr_data,
  input  logic               req_valid,
  input  logic               req_arith,
  input  logic               req_huge,
  input  logic [1:0]         req_sel,
  input  logic [15:0]        req_off,
  input  logic [31:0]        req_delta,
  output logic               out_valid,
  output logic [19:0]        out_phys,
  output logic [15:0]        out_seg,
  output logic [15:0]        out_off
);
  logic [SEG_W-1:0]         sel_seg;
  logic [NUM_SEG*SEG_W-1:0] seg_flat;
  logic [PHYS_W-1:0]        in_phys;
  logic [PHYS_W-1:0]        res_phys;
  far_ptr_t                 in_ptr;
  far_ptr_t                 math_ptr;
  far_ptr_t                 res_ptr;
  ptr_mode_e                mode;

  logic                     valid_d, valid_q;
  logic [PHYS_W-1:0]        phys_d, phys_q;
  far_ptr_t                 ptr_d, ptr_q;

  seg_regfile u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_sel   (wr_sel),
    .wr_data  (wr_data),
    .rd_sel   (req_sel),
    .rd_data  (sel_seg),
    .seg_flat (seg_flat)
  );

  assign in_ptr.seg = sel_seg;
  assign in_ptr.off = req_off;
  assign mode       = ptr_mode_e'(req_huge);

  seg_phys_calc u_in_phys (
    .seg  (in_ptr.seg),
    .off  (in_ptr.off),
    .phys (in_phys)
  );

  seg_ptr_math u_math (
    .ptr_in  (in_ptr),
    .mode    (mode),
    .delta   (req_delta),
    .lin_in  (in_phys),
    .ptr_out (math_ptr)
  );

  assign res_ptr = req_arith ? math_ptr : in_ptr;

  seg_phys_calc u_res_phys (
    .seg  (res_ptr.seg),
    .off  (res_ptr.off),
    .phys (res_phys)
  );

  always_comb begin
    valid_d = req_valid;
    phys_d  = phys_q;
    ptr_d   = ptr_q;
    if (req_valid) begin
      phys_d = res_phys;
      ptr_d  = res_ptr;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      phys_q  <= '0;
      ptr_q   <= '0;
    end else begin
      valid_q <= valid_d;
      phys_q  <= phys_d;
      ptr_q   <= ptr_d;
    end
  end

  assign out_valid = valid_q;
  assign out_phys  = phys_q;
  assign out_seg   = ptr_q.seg;
  assign out_off   = ptr_q.off;
endmodule

// File: rtl/seg_addr_chk.sv
module seg_addr_chk
  import seg_addr_pkg::*;
(
  input logic                     clk,
  input logic                     rst_n,
  input logic                     wr_en,
  input logic [1:0]               wr_sel,
  input logic [15:0]              wr_data,
  input logic                     req_valid,
  input logic                     req_arith,
  input logic                     req_huge,
  input logic [15:0]              req_off,
  input logic [31:0]              req_delta,
  input logic                     out_valid,
  input logic [19:0]              out_phys,
  input logic [15:0]              out_seg,
  input logic [15:0]              out_off,
  input logic [NUM_SEG*SEG_W-1:0] seg_flat
);
  logic             wr_en_q;
  logic [1:0]       wr_sel_q;
  logic [15:0]      wr_data_q;
  logic [19:0]      out_recalc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_en_q   <= 1'b0;
      wr_sel_q  <= '0;
      wr_data_q <= '0;
    end else begin
      wr_en_q   <= wr_en;
      wr_sel_q  <= wr_sel;
      wr_data_q <= wr_data;
    end
  end

  assign out_recalc = {out_seg, 4'h0} + {4'h0, out_off};

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> out_valid); // R8
  AST_VALID_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !out_valid); // R8
  AST_PHYS_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_phys == out_recalc); // R9
  AST_ADDR_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_arith) |=> out_off == $past(req_off)); // R2
  AST_FAR_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_arith && !req_huge) |=>
      out_off == $past(req_off + req_delta[15:0])); // R5
  AST_HUGE_NORM: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_arith && req_huge) |=> out_off[15:4] == 12'h000); // R6
  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_q |-> seg_flat[wr_sel_q*SEG_W +: SEG_W] == wr_data_q); // R4
endmodule

bind seg_addr_unit seg_addr_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .wr_en     (wr_en),
  .wr_sel    (wr_sel),
  .wr_data   (wr_data),
  .req_valid (req_valid),
  .req_arith (req_arith),
  .req_huge  (req_huge),
  .req_off   (req_off),
  .req_delta (req_delta),
  .out_valid (out_valid),
  .out_phys  (out_phys),
  .out_seg   (out_seg),
  .out_off   (out_off),
  .seg_flat  (seg_flat)
);

// File: tb/tb_seg_addr_unit.sv
module tb_seg_addr_unit;
  localparam int CLK_PERIOD = 10;

  logic        clk;
  logic        rst_n;
  logic        wr_en;
  logic [1:0]  wr_sel;
  logic [15:0] wr_data;
  logic        req_valid;
  logic        req_arith;
  logic        req_huge;
  logic [1:0]  req_sel;
  logic [15:0] req_off;
  logic [31:0] req_delta;
  logic        out_valid;
  logic [19:0] out_phys;
  logic [15:0] out_seg;
  logic [15:0] out_off;

  int total = 0;
  int bad   = 0;

  seg_addr_unit dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .req_valid(req_valid), .req_arith(req_arith), .req_huge(req_huge),
    .req_sel(req_sel), .req_off(req_off), .req_delta(req_delta),
    .out_valid(out_valid), .out_phys(out_phys), .out_seg(out_seg), .out_off(out_off)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic write_seg(logic [1:0] sel, logic [15:0] val);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = val;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // one request; result is checked on the following negedge
  task automatic request(logic arith, logic huge, logic [1:0] sel,
                         logic [15:0] off, logic [31:0] delta);
    @(negedge clk);
    req_valid = 1'b1; req_arith = arith; req_huge = huge;
    req_sel = sel; req_off = off; req_delta = delta;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic expect_out(string req, logic [19:0] phys, logic [15:0] seg, logic [15:0] off);
    check(req, "valid", 32'(out_valid), 32'd1);
    check(req, "phys", 32'(out_phys), 32'(phys));
    check(req, "seg", 32'(out_seg), 32'(seg));
    check(req, "off", 32'(out_off), 32'(off));
  endtask

  task automatic t_reset;
    check("R8", "valid after reset", 32'(out_valid), 32'd0);
    for (int i = 0; i < 4; i++) begin
      request(1'b0, 1'b0, 2'(i), 16'h1234, 32'h0);
      expect_out("R1", 20'h01234, 16'h0000, 16'h1234);
    end
  endtask

  task automatic t_phys;
    write_seg(2'd2, 16'h1234);
    request(1'b0, 1'b0, 2'd2, 16'h0005, 32'h0);
    expect_out("R2", 20'h12345, 16'h1234, 16'h0005);
    @(negedge clk);
    check("R8", "valid drops when idle", 32'(out_valid), 32'd0);
  endtask

  task automatic t_alias;
    write_seg(2'd0, 16'h1000);
    write_seg(2'd1, 16'h0FFF);
    write_seg(2'd3, 16'h0001);
    request(1'b0, 1'b0, 2'd0, 16'h0000, 32'h0);
    check("R3", "alias a", 32'(out_phys), 32'h10000);
    request(1'b0, 1'b0, 2'd1, 16'h0010, 32'h0);
    check("R3", "alias b", 32'(out_phys), 32'h10000);
    request(1'b0, 1'b0, 2'd3, 16'hFFF0, 32'h0);
    check("R3", "alias c", 32'(out_phys), 32'h10000);
  endtask

  task automatic t_write_timing;
    @(negedge clk);
    wr_en = 1'b1; wr_sel = 2'd1; wr_data = 16'h4000;
    req_valid = 1'b1; req_arith = 1'b0; req_huge = 1'b0;
    req_sel = 2'd1; req_off = 16'h0000; req_delta = '0;
    @(negedge clk);
    wr_en = 1'b0; req_valid = 1'b0;
    expect_out("R4", 20'h0FFF0, 16'h0FFF, 16'h0000);
    request(1'b0, 1'b0, 2'd1, 16'h0000, 32'h0);
    expect_out("R4", 20'h40000, 16'h4000, 16'h0000);
  endtask

  task automatic t_wrap;
    write_seg(2'd3, 16'hFFFF);
    request(1'b0, 1'b0, 2'd3, 16'h0010, 32'h0);
    expect_out("R7", 20'h00000, 16'hFFFF, 16'h0010);
    request(1'b0, 1'b0, 2'd3, 16'hFFFF, 32'h0);
    expect_out("R7", 20'h0FFEF, 16'hFFFF, 16'hFFFF);
    request(1'b1, 1'b1, 2'd3, 16'h000F, 32'h1);
    expect_out("R7", 20'h00000, 16'h0000, 16'h0000);
  endtask

  task automatic t_far;
    write_seg(2'd0, 16'h2000);
    request(1'b1, 1'b0, 2'd0, 16'hFFF0, 32'h20);
    expect_out("R5", 20'h20010, 16'h2000, 16'h0010);
    request(1'b1, 1'b0, 2'd0, 16'h0010, 32'hFFFF_FFD0);
    expect_out("R5", 20'h2FFE0, 16'h2000, 16'hFFE0);
    request(1'b1, 1'b0, 2'd0, 16'h0010, 32'h0001_0005);
    expect_out("R5", 20'h20015, 16'h2000, 16'h0015);
  endtask

  task automatic t_huge;
    request(1'b1, 1'b1, 2'd0, 16'hFFF0, 32'h20);
    expect_out("R6", 20'h30010, 16'h3001, 16'h0000);
    write_seg(2'd2, 16'h3000);
    request(1'b1, 1'b1, 2'd2, 16'h0000, 32'hFFFF_FFFF);
    expect_out("R6", 20'h2FFFF, 16'h2FFF, 16'h000F);
    write_seg(2'd2, 16'h0000);
    request(1'b1, 1'b1, 2'd2, 16'h0000, 32'h0001_2345);
    expect_out("R9", 20'h12345, 16'h1234, 16'h0005);
  endtask

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_sel = '0; wr_data = '0;
    req_valid = 1'b0; req_arith = 1'b0; req_huge = 1'b0;
    req_sel = '0; req_off = '0; req_delta = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_phys();
    t_alias();
    t_write_timing();
    t_wrap();
    t_far();
    t_huge();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog run did not finish actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule